// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between the two ports of a shared memory and resolves the case where both ports select the same word in the same cycle. Each port has an address, a chip enable, a write strobe, write data and read data. Each port also has an active-low busy indication, split into a driven output and a separate input. A static mode pin chooses how the busy logic works.

In master mode the block decides the conflict itself. It compares the two addresses, with both chip enables active, and does not look at the write strobes. One port keeps its access and the other port sees busy driven low. Both busy outputs are always driven to a definite level, high or low. A write from the busy port is gated off inside the block, so the array keeps the winner's data. In slave mode no arbitration is done. The busy outputs stay high, and each port's busy input acts only as a write inhibit for that port. A small behavioural array behind the gates shows at the read ports which writes took effect.

A write takes effect only once its access is settled: the address and chip enable must have been steady for a cycle. The block enforces this, so a write strobe in the first cycle of a new access changes nothing. With this rule the write-inhibit gate never acts on a half-decided arbitration.

Top module: `dpbusy_arbiter`

## Requirements
- R1: After reset both busy outputs read 1 (inactive), with both ports idle.
- R2: In master mode, when both ports begin an access to the same address in the same cycle, the left port is granted. From the next cycle the right busy output is 0 and the left busy output is 1. The two busy outputs are never 0 together.
- R3: In master mode, when one port already holds a settled access to an address and the other port then arrives at that address, the holder is granted. The arriving port sees busy 0 from the next cycle.
- R4: Arbitration uses only chip enables and addresses. Two reads of the same address collide and assert busy just as writes do.
- R5: A write strobe from the port whose busy is 0 leaves the array word unchanged.
- R6: When the granted port drops its chip enable or changes its address, the other port's busy returns to 1 one cycle later. A write it keeps strobing takes effect on the cycle after that.
- R7: A write takes effect only when the port's chip enable and address were the same in the previous cycle. A strobe in the first cycle of a new access is dropped.
- R8: Different addresses, or only one enabled port, never assert busy on either port.
- R9: In slave mode (mode pin 0) both busy outputs stay 1. A port's busy input at 0 blocks every write from that port, and at 1 it leaves writes normal.
- R10: In slave mode two settled writes to the same address in the same cycle both pass the gates, and the left port's data is the value kept.
- R11: Each port's read data shows the array word at that port's current address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (arbitrate), 0 = slave (busy inputs inhibit writes) |
| l_en | input | 1 | Left chip enable, active high |
| l_addr | input | AW | Left word address |
| l_we | input | 1 | Left write strobe |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data |
| l_busy_n_in | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_out | output | 1 | Left busy indication in master mode, active low |
| r_en | input | 1 | Right chip enable, active high |
| r_addr | input | AW | Right word address |
| r_we | input | 1 | Right write strobe |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data |
| r_busy_n_in | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_out | output | 1 | Right busy indication in master mode, active low |

## Verification
The hardest case to reach is the hand-over. A port that lost arbitration must go on strobing its write through the whole conflict and the release, and its data must land exactly one cycle after busy clears, never earlier. The stimulus first fills the word with a known value through the left port alone. It then holds the losing port's address and strobe steady across the winner's release, either by dropping the chip enable or by changing the address. It reads the word back after each cycle, so a write that slipped through or arrived late shows as a wrong value.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    GRANT_NONE  = 2'd0,
    GRANT_LEFT  = 2'd1,
    GRANT_RIGHT = 2'd2
  } grant_e;
endpackage

// File: rtl/dpb_port_track.sv
// Remembers the previous access of one port and flags when the current
// access is settled (same enable and address as last cycle).
module dpb_port_track #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          held
);
  logic          prev_en_q, prev_en_d;
  logic [AW-1:0] prev_addr_q, prev_addr_d;

  always_comb begin
    prev_en_d   = en;
    prev_addr_d = en ? addr : prev_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q   <= prev_en_d;
      prev_addr_q <= prev_addr_d;
    end
  end

  assign held = en && prev_en_q && (addr == prev_addr_q);
endmodule

// File: rtl/dpb_arbiter.sv
// Grant state for a two-port address conflict.
module dpb_arbiter
  import dpb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master_sel,
  input  logic   collide,
  input  logic   l_held,
  input  logic   r_held,
  output grant_e grant_q
);
  grant_e grant_d;

  always_comb begin
    grant_d = GRANT_NONE;
    if (master_sel && collide) begin
      if (grant_q == GRANT_LEFT && l_held)        grant_d = GRANT_LEFT;
      else if (grant_q == GRANT_RIGHT && r_held)  grant_d = GRANT_RIGHT;
      else if (r_held && !l_held)                 grant_d = GRANT_RIGHT;
      else                                        grant_d = GRANT_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= GRANT_NONE;
    else        grant_q <= grant_d;
  end
endmodule

// File: rtl/dpb_mem.sv
// Behavioural two-port word array; left write takes precedence on a tie.
module dpb_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (r_wr) words[r_addr] <= r_wdata;
    if (l_wr) words[l_addr] <= l_wdata;
  end

  assign l_rdata = words[l_addr];
  assign r_rdata = words[r_addr];
endmodule

// File: rtl/dpbusy_arbiter.sv
module dpbusy_arbiter
  import dpb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_n_in,
  output logic          l_busy_n_out,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_n_in,
  output logic          r_busy_n_out
);
  localparam int NPORT = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NPORT-1:0] en_vec;
  logic [AW-1:0]    addr_vec [NPORT];
  logic [NPORT-1:0] held_vec;

  assign en_vec      = {r_en, l_en};
  assign addr_vec[0] = l_addr;
  assign addr_vec[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    dpb_port_track #(.AW(AW)) u_track (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .en   (en_vec[p]),
      .addr (addr_vec[p]),
      .held (held_vec[p])
    );
  end

  logic   collide;
  grant_e grant_q;

  assign collide = l_en && r_en && (l_addr == r_addr);

  dpb_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .master_sel(master_sel),
    .collide   (collide),
    .l_held    (held_vec[0]),
    .r_held    (held_vec[1]),
    .grant_q   (grant_q)
  );

  // effective inhibit per port: arbitration in master, pin in slave
  logic l_block, r_block;
  always_comb begin
    if (master_sel) begin
      l_block = (grant_q == GRANT_RIGHT);
      r_block = (grant_q == GRANT_LEFT);
    end else begin
      l_block = !l_busy_n_in;
      r_block = !r_busy_n_in;
    end
  end

  assign l_busy_n_out = !(master_sel && grant_q == GRANT_RIGHT);
  assign r_busy_n_out = !(master_sel && grant_q == GRANT_LEFT);

  logic l_wr, r_wr;
  assign l_wr = l_we && held_vec[0] && !l_block && rst_sync_n;
  assign r_wr = r_we && held_vec[1] && !r_block && rst_sync_n;

  dpb_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .l_wr   (l_wr),
    .l_addr (l_addr),
    .l_wdata(l_wdata),
    .l_rdata(l_rdata),
    .r_wr   (r_wr),
    .r_addr (r_addr),
    .r_wdata(r_wdata),
    .r_rdata(r_rdata)
  );
endmodule

// File: rtl/dpbusy_arbiter_chk.sv
module dpbusy_arbiter_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_sel,
  input logic          l_en,
  input logic          r_en,
  input logic [AW-1:0] l_addr,
  input logic [AW-1:0] r_addr,
  input logic          l_we,
  input logic          r_we,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy_n_out,
  input logic          r_busy_n_out,
  input logic          l_held,
  input logic          r_held
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic coll;
  assign coll = l_en && r_en && (l_addr == r_addr);

  assert_busy_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n_out && !r_busy_n_out));

  assert_tie_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && coll && !l_held && !r_held) |=> (!r_busy_n_out && l_busy_n_out));

  assert_no_busy_without_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(coll)) |-> (l_busy_n_out && r_busy_n_out));

  assert_slave_outputs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (l_busy_n_out && r_busy_n_out));

  assert_busy_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !l_busy_n_out && l_en && l_we && !r_we)
      |=> ((l_addr != $past(l_addr)) || $stable(l_rdata)));

  assert_fresh_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && l_en && l_we && !r_en && (!$past(l_en) || l_addr != $past(l_addr)))
      |=> ((l_addr != $past(l_addr)) || $stable(l_rdata)));
endmodule

bind dpbusy_arbiter dpbusy_arbiter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .master_sel  (master_sel),
  .l_en        (l_en),
  .r_en        (r_en),
  .l_addr      (l_addr),
  .r_addr      (r_addr),
  .l_we        (l_we),
  .r_we        (r_we),
  .l_rdata     (l_rdata),
  .l_busy_n_out(l_busy_n_out),
  .r_busy_n_out(r_busy_n_out),
  .l_held      (held_vec[0]),
  .r_held      (held_vec[1])
);

// File: tb/dpbusy_arbiter_test.sv
module dpbusy_arbiter_test;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1;
  logic l_en = 1'b0, r_en = 1'b0, l_we = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n_in = 1'b1, r_busy_n_in = 1'b1;
  logic l_busy_n_out, r_busy_n_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dpbusy_arbiter #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .l_en(l_en), .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n_in(l_busy_n_in), .l_busy_n_out(l_busy_n_out),
    .r_en(r_en), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n_in(r_busy_n_in), .r_busy_n_out(r_busy_n_out)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    step(1);
  endtask

  // left port alone writes a word (settled on second edge)
  task automatic lwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = 1; l_addr = a; l_we = 1; l_wdata = d;
    step(2);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; step(3); rst_n = 1; step(3);
    chk("R1 left busy", {15'd0, l_busy_n_out}, 16'd1);
    chk("R1 right busy", {15'd0, r_busy_n_out}, 16'd1);
  endtask

  task automatic t_tie();
    lwrite(6'd5, 16'h0000);
    l_en = 1; l_addr = 6'd5; l_we = 1; l_wdata = 16'h1111;
    r_en = 1; r_addr = 6'd5; r_we = 1; r_wdata = 16'h2222;
    step(1);
    chk("R2 right busy", {15'd0, r_busy_n_out}, 16'd0);
    chk("R2 left free", {15'd0, l_busy_n_out}, 16'd1);
    step(1);
    chk("R5 winner data kept", l_rdata, 16'h1111);
    chk("R2 right still busy", {15'd0, r_busy_n_out}, 16'd0);
    l_en = 0; l_we = 0;
    step(1);
    chk("R6 busy cleared after enable drop", {15'd0, r_busy_n_out}, 16'd1);
    chk("R6 no early write", r_rdata, 16'h1111);
    step(1);
    chk("R6 waiting write lands", r_rdata, 16'h2222);
    idle();
  endtask

  task automatic t_held_wins();
    lwrite(6'd9, 16'h1234);
    r_en = 1; r_addr = 6'd9; r_we = 0;
    step(2);
    l_en = 1; l_addr = 6'd9; l_we = 1; l_wdata = 16'hAAAA;
    step(1);
    chk("R3 left busy", {15'd0, l_busy_n_out}, 16'd0);
    chk("R3 holder free", {15'd0, r_busy_n_out}, 16'd1);
    step(2);
    chk("R5 busy write blocked", r_rdata, 16'h1234);
    r_addr = 6'd10;
    step(1);
    chk("R6 busy cleared after address change", {15'd0, l_busy_n_out}, 16'd1);
    chk("R6 no early write", l_rdata, 16'h1234);
    step(1);
    chk("R6 waiting write lands", l_rdata, 16'hAAAA);
    idle();
  endtask

  task automatic t_read_collide();
    l_en = 1; l_addr = 6'd3; r_en = 1; r_addr = 6'd3;
    step(1);
    chk("R4 read collision busy", {15'd0, r_busy_n_out}, 16'd0);
    idle();
  endtask

  task automatic t_fresh();
    lwrite(6'd20, 16'h0F0F);
    l_en = 1; l_addr = 6'd20; l_we = 1; l_wdata = 16'hDEAD;
    step(1);
    l_en = 0; l_we = 0;
    step(1);
    chk("R7 fresh strobe dropped", l_rdata, 16'h0F0F);
    chk("R11 read follows word", l_rdata, 16'h0F0F);
  endtask

  task automatic t_nocollide();
    l_en = 1; l_addr = 6'd1; l_we = 1; l_wdata = 16'h0101;
    r_en = 1; r_addr = 6'd2; r_we = 1; r_wdata = 16'h0202;
    step(1);
    chk("R8 left free", {15'd0, l_busy_n_out}, 16'd1);
    chk("R8 right free", {15'd0, r_busy_n_out}, 16'd1);
    step(1);
    chk("R8 left wrote", l_rdata, 16'h0101);
    chk("R8 right wrote", r_rdata, 16'h0202);
    r_en = 0; r_we = 0; r_addr = 6'd1; l_we = 0;
    step(1);
    chk("R8 one port enabled free", {15'd0, r_busy_n_out}, 16'd1);
    chk("R11 right reads left word", r_rdata, 16'h0101);
    idle();
  endtask

  task automatic t_slave();
    lwrite(6'd30, 16'h0001);
    master_sel = 0; step(1);
    l_busy_n_in = 0;
    l_en = 1; l_addr = 6'd30; l_we = 1; l_wdata = 16'hBEEF;
    r_en = 1; r_addr = 6'd31; r_we = 1; r_wdata = 16'hCAFE;
    step(2);
    chk("R9 inhibited write", l_rdata, 16'h0001);
    chk("R9 normal write", r_rdata, 16'hCAFE);
    idle();
    l_busy_n_in = 1;
    l_en = 1; l_addr = 6'd40; l_we = 1; l_wdata = 16'h1111;
    r_en = 1; r_addr = 6'd40; r_we = 1; r_wdata = 16'h2222;
    step(1);
    chk("R9 left out high", {15'd0, l_busy_n_out}, 16'd1);
    chk("R9 right out high", {15'd0, r_busy_n_out}, 16'd1);
    step(1);
    chk("R10 left data kept", r_rdata, 16'h1111);
    idle();
    master_sel = 1; step(1);
  endtask

  initial begin
    t_reset();
    t_tie();
    t_held_wins();
    t_read_collide();
    t_fresh();
    t_nocollide();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule